// File: doc/BRIEF.md
# CPU Interrupt Acceptance Controller

This block decides, at every instruction boundary of a small 8-bit CPU core, whether the core starts an interrupt response. It holds the two interrupt-enable flip-flops (a primary `iff1` that gates maskable acceptance and a shadow `iff2` that preserves it across a non-maskable response). It updates them from decoded instruction events that the core presents together with the boundary strobe: enable, disable, return-from-interrupt and return-from-NMI.

The maskable request is an active-low level that is examined only at boundaries. The non-maskable request is captured on its falling edge and stays pending until it is accepted. When a non-maskable response starts, the block raises a push-PC request and presents the fixed restart address. It then holds an acknowledge-busy window that is as long as the acknowledge machine cycle. For a maskable acceptance it only raises `takeInt`; the core handles the vectoring.

All timing is counted in core clock cycles, one per T-state. `takeNmi`, `takeInt`, `pushPc` and `nmiVector` are combinational and valid in the boundary cycle. The enable flip-flops and the busy flag change at the clock edge that closes that cycle.

Top module: `irq_accept_ctrl`

## Requirements
- R1: After reset `iff1`, `iff2`, `nmiAckBusy`, `takeNmi`, `takeInt` and `pushPc` are all 0 and no non-maskable request is pending.
- R2: At a boundary with `isDi` high both enable flip-flops become 0, and no maskable request is taken at that boundary. With `isEi` high (and `isDi` low) both become 1.
- R3: A maskable request (`intN` low) is taken at a boundary when `iff1`, after that boundary's instruction event, is 1, no deferral is active, no NMI is taken and the block is not busy. Accepting it clears both enable flip-flops.
- R4: No maskable request is taken at the boundary that completes the enable instruction. It can be taken at the next boundary.
- R5: A return-from-interrupt or return-from-NMI copies `iff2` into `iff1`. It defers maskable acceptance at its own boundary only when `iff1` and `iff2` differed before it.
- R6: A falling edge on `nmiN` makes a request pending that no instruction can mask. The request holds until it is accepted. A low level held without a new edge does not raise another request.
- R7: When a non-maskable request is pending at a boundary it is taken and `takeInt` stays 0, even if a maskable request is also valid.
- R8: In the cycle an NMI is taken, `pushPc` is 1 and `nmiVector` equals 0x0066. At the closing edge `iff1` becomes 0 and `iff2` keeps its value.
- R9: `nmiAckBusy` is 1 for exactly 5 cycles, starting in the cycle after the NMI is taken.
- R10: While `nmiAckBusy` is 1 neither request is taken. An NMI edge that arrives in that window stays pending and is taken at the first boundary after the window.
- R11: With `instrBoundary` low nothing is taken and the instruction event inputs have no effect on the enable flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one cycle per T-state |
| rstN | input | 1 | Active-low synchronous reset |
| instrBoundary | input | 1 | High for the one cycle in which an instruction completes |
| isEi | input | 1 | Completed instruction is the enable instruction |
| isDi | input | 1 | Completed instruction is the disable instruction |
| isReti | input | 1 | Completed instruction is return-from-interrupt |
| isRetn | input | 1 | Completed instruction is return-from-NMI |
| intN | input | 1 | Maskable request, active-low level |
| nmiN | input | 1 | Non-maskable request, falling-edge sensitive |
| takeNmi | output | 1 | Start a non-maskable response at this boundary |
| takeInt | output | 1 | Start a maskable response at this boundary |
| pushPc | output | 1 | Push the program counter for the NMI response |
| nmiVector | output | 16 | Restart address 0x0066 while `takeNmi` is high, else 0 |
| iff1 | output | 1 | Primary interrupt-enable flip-flop |
| iff2 | output | 1 | Shadow interrupt-enable flip-flop |
| nmiAckBusy | output | 1 | NMI acknowledge cycle in progress |

## Verification
Two functions can coincide at a single boundary. A pending NMI and a valid maskable request can meet in one boundary cycle. A maskable request can also meet the event of the instruction that just completed (enable, disable or a return). The bench sets up each case on purpose. It holds `intN` low while an NMI edge is pending, and it holds `intN` low on the boundaries of the enable, disable and return instructions. It judges the case by which of `takeNmi` and `takeInt` is high in that cycle and by the enable flip-flops one cycle later. It also asserts a new NMI edge inside the acknowledge window. It checks that the edge is held and taken only at the first boundary after the window.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

  // Strobes the control half hands to the state-holding half.
  typedef struct packed {
    logic takeNmi;
    logic takeInt;
  } ctrlStrobes_t;

endpackage

// File: rtl/irq_state.sv
module irq_state
  import irq_accept_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrBoundary,
  input  logic         isEi,
  input  logic         isDi,
  input  logic         isReti,
  input  logic         isRetn,
  input  logic         nmiN,
  input  ctrlStrobes_t strb,
  output logic         iff1,
  output logic         iff2,
  output logic         iff1Next,
  output logic         nmiPending
);

  logic iff1Q, iff2Q, nmiPrevQ, nmiPendQ;
  logic iff1Ev, iff2Ev, nmiFall;

  // Apply the completed instruction's event (disable has precedence).
  always_comb begin
    iff1Ev = iff1Q;
    iff2Ev = iff2Q;
    if (instrBoundary) begin
      if (isDi) begin
        iff1Ev = 1'b0;
        iff2Ev = 1'b0;
      end else if (isEi) begin
        iff1Ev = 1'b1;
        iff2Ev = 1'b1;
      end else if (isReti || isRetn) begin
        iff1Ev = iff2Q;
      end
    end
  end

  assign nmiFall = nmiPrevQ & ~nmiN;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      iff1Q    <= 1'b0;
      iff2Q    <= 1'b0;
      nmiPrevQ <= 1'b1;
      nmiPendQ <= 1'b0;
    end else begin
      iff1Q    <= (strb.takeNmi || strb.takeInt) ? 1'b0 : iff1Ev;
      iff2Q    <= strb.takeInt ? 1'b0 : iff2Ev;
      nmiPrevQ <= nmiN;
      nmiPendQ <= nmiFall | (nmiPendQ & ~strb.takeNmi);
    end
  end

  assign iff1       = iff1Q;
  assign iff2       = iff2Q;
  assign iff1Next   = iff1Ev;
  assign nmiPending = nmiPendQ;

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_accept_pkg::*;
#(
  parameter int ACK_TSTATES = 5
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         instrBoundary,
  input  logic         isEi,
  input  logic         isReti,
  input  logic         isRetn,
  input  logic         intN,
  input  logic         iff1,
  input  logic         iff2,
  input  logic         iff1Next,
  input  logic         nmiPending,
  output ctrlStrobes_t strb,
  output logic         ackBusy
);

  localparam int CNT_W = $clog2(ACK_TSTATES + 1);
  localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(ACK_TSTATES);

  logic [CNT_W-1:0] ackCntQ;
  logic             deferNow, gate;

  // One-instruction hold-off after enable, or after a return that
  // finds the two enable flip-flops in disagreement.
  assign deferNow = isEi | ((isReti | isRetn) & (iff1 ^ iff2));
  assign ackBusy  = (ackCntQ != '0);
  assign gate     = instrBoundary & ~ackBusy;

  always_comb begin
    strb.takeNmi = gate & nmiPending;
    strb.takeInt = gate & ~nmiPending & ~intN & iff1Next & ~deferNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackCntQ <= '0;
    end else if (strb.takeNmi) begin
      ackCntQ <= ACK_LOAD;
    end else if (ackBusy) begin
      ackCntQ <= ackCntQ - 1'b1;
    end
  end

endmodule

// File: rtl/irq_accept_ctrl.sv
module irq_accept_ctrl
  import irq_accept_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] NMI_ADDR    = 16'h0066,
  parameter int                ACK_TSTATES = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              instrBoundary,
  input  logic              isEi,
  input  logic              isDi,
  input  logic              isReti,
  input  logic              isRetn,
  input  logic              intN,
  input  logic              nmiN,
  output logic              takeNmi,
  output logic              takeInt,
  output logic              pushPc,
  output logic [ADDR_W-1:0] nmiVector,
  output logic              iff1,
  output logic              iff2,
  output logic              nmiAckBusy
);

  ctrlStrobes_t strb;
  logic         iff1Next, nmiPending;

  irq_state u_state (
    .clk           (clk),
    .rstN          (rstN),
    .instrBoundary (instrBoundary),
    .isEi          (isEi),
    .isDi          (isDi),
    .isReti        (isReti),
    .isRetn        (isRetn),
    .nmiN          (nmiN),
    .strb          (strb),
    .iff1          (iff1),
    .iff2          (iff2),
    .iff1Next      (iff1Next),
    .nmiPending    (nmiPending)
  );

  irq_ctrl #(.ACK_TSTATES(ACK_TSTATES)) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .instrBoundary (instrBoundary),
    .isEi          (isEi),
    .isReti        (isReti),
    .isRetn        (isRetn),
    .intN          (intN),
    .iff1          (iff1),
    .iff2          (iff2),
    .iff1Next      (iff1Next),
    .nmiPending    (nmiPending),
    .strb          (strb),
    .ackBusy       (nmiAckBusy)
  );

  assign takeNmi   = strb.takeNmi;
  assign takeInt   = strb.takeInt;
  assign pushPc    = strb.takeNmi;
  assign nmiVector = strb.takeNmi ? NMI_ADDR : '0;

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              instrBoundary,
  input logic              isEi,
  input logic              isDi,
  input logic              takeNmi,
  input logic              takeInt,
  input logic              pushPc,
  input logic [ADDR_W-1:0] nmiVector,
  input logic              iff1,
  input logic              iff2,
  input logic              nmiAckBusy
);

  p_di_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && isDi) |=> (!iff1 && !iff2));

  p_di_no_int_r2: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && isDi) |-> !takeInt);

  p_int_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    takeInt |=> (!iff1 && !iff2));

  p_ei_defer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (instrBoundary && isEi) |-> !takeInt);

  p_nmi_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |-> !takeInt);

  p_nmi_push_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |-> (pushPc && nmiVector == ADDR_W'(16'h0066)));

  p_nmi_iff1_r8: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |=> !iff1);

  p_nmi_iff2_r8: assert property (@(posedge clk) disable iff (!rstN)
    (takeNmi && !isEi && !isDi) |=> (iff2 == $past(iff2)));

  p_busy_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    takeNmi |=> nmiAckBusy);

  p_busy_block_r10: assert property (@(posedge clk) disable iff (!rstN)
    nmiAckBusy |-> (!takeNmi && !takeInt));

  p_no_boundary_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instrBoundary |-> (!takeNmi && !takeInt));

  p_iff_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !instrBoundary |=> ($stable(iff1) && $stable(iff2)));

endmodule

bind irq_accept_ctrl irq_accept_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_irq_accept_ctrl.sv
module test_irq_accept_ctrl;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      req;
    logic [5:0] msk;
    logic [5:0] val;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        instrBoundary = 1'b0, isEi = 1'b0, isDi = 1'b0;
  logic        isReti = 1'b0, isRetn = 1'b0, intN = 1'b1, nmiN = 1'b1;
  logic        takeNmi, takeInt, pushPc, iff1, iff2, nmiAckBusy;
  logic [15:0] nmiVector;

  int       checks = 0, failures = 0;
  bit       done = 1'b0;
  expItem_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_accept_ctrl i_irq_accept_ctrl (
    .clk(clk), .rstN(rstN), .instrBoundary(instrBoundary),
    .isEi(isEi), .isDi(isDi), .isReti(isReti), .isRetn(isRetn),
    .intN(intN), .nmiN(nmiN), .takeNmi(takeNmi), .takeInt(takeInt),
    .pushPc(pushPc), .nmiVector(nmiVector), .iff1(iff1), .iff2(iff2),
    .nmiAckBusy(nmiAckBusy)
  );

  // Driver: one call = one cycle. Bits {takeNmi,takeInt,pushPc,iff1,iff2,busy}.
  task automatic cyc(input logic b, ei, di, reti, retn, iN, nN,
                     input string req, input logic [5:0] msk, val);
    expItem_t it;
    @(negedge clk);
    instrBoundary = b; isEi = ei; isDi = di; isReti = reti; isRetn = retn;
    intN = iN; nmiN = nN;
    #(CLK_PERIOD/4);
    it.req = req; it.msk = msk; it.val = val;
    expQ.push_back(it);
  endtask

  // Monitor: pops expectations and compares with the outputs.
  initial begin
    forever begin
      expItem_t it;
      logic [5:0] got;
      wait (expQ.size() != 0);
      it  = expQ.pop_front();
      got = {takeNmi, takeInt, pushPc, iff1, iff2, nmiAckBusy};
      if (it.msk != '0) begin
        checks++;
        if ((got & it.msk) != (it.val & it.msk)) begin
          failures++;
          $display("FAIL %s got=%b exp=%b", it.req, got, it.val);
        end
        if (it.val[5] && it.msk[5] && nmiVector != 16'h0066) begin
          failures++;
          $display("FAIL %s vector got=%h exp=0066", it.req, nmiVector);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    cyc(0,0,0,0,0,1,1, "R1 reset state",            6'h3F, 6'b000000);
    cyc(0,1,0,0,0,0,1, "R11 no boundary no take",   6'h3F, 6'b000000);
    cyc(1,1,0,0,0,0,1, "R4 no int at EI boundary",  6'h3F, 6'b000000);
    cyc(0,0,0,0,0,1,1, "R2 EI sets both",           6'h3F, 6'b000110);
    cyc(1,0,0,0,0,0,1, "R3 R4 int taken next",      6'h3F, 6'b010110);
    cyc(0,0,0,0,0,1,1, "R3 accept clears both",     6'h3F, 6'b000000);
    cyc(1,1,0,0,0,1,1, "R2 EI boundary",            6'h3F, 6'b000000);
    cyc(1,0,1,0,0,0,1, "R2 no int at DI boundary",  6'h3F, 6'b000110);
    cyc(0,0,0,0,0,1,1, "R2 DI clears both",         6'h3F, 6'b000000);
    // NMI against a valid maskable request
    cyc(1,1,0,0,0,1,1, "R2 EI again",               6'h00, 6'b000000);
    cyc(0,0,0,0,0,1,0, "R6 edge not yet taken",     6'h3F, 6'b000110);
    cyc(1,0,0,0,0,0,0, "R7 R8 nmi wins push",       6'h3F, 6'b101110);
    cyc(0,0,0,0,0,1,1, "R8 R9 iff1 cleared busy",   6'h3F, 6'b000011);
    cyc(0,0,0,0,0,1,0, "R9 busy 2",                 6'h3F, 6'b000011);
    cyc(1,0,0,0,0,0,0, "R10 blocked while busy",    6'h3F, 6'b000011);
    cyc(0,0,0,0,0,1,1, "R9 busy 4",                 6'h3F, 6'b000011);
    cyc(0,0,0,0,0,1,1, "R9 busy 5",                 6'h3F, 6'b000011);
    cyc(0,0,0,0,0,1,1, "R9 busy ends",              6'h3F, 6'b000010);
    cyc(1,0,0,0,0,1,1, "R10 R6 held nmi taken",     6'h3F, 6'b101010);
    cyc(0,0,0,0,0,1,1, "R9 busy again",             6'h3F, 6'b000011);
    for (int i = 0; i < 4; i++)
      cyc(0,0,0,0,0,1,1, "R9 busy hold",            6'h01, 6'b000001);
    cyc(0,0,0,0,0,1,1, "R9 busy off",               6'h3F, 6'b000010);
    // Returns
    cyc(1,0,0,0,1,0,1, "R5 retn defers on differ",  6'h3F, 6'b000010);
    cyc(0,0,0,0,0,1,1, "R5 retn copies iff2",       6'h3F, 6'b000110);
    cyc(1,0,0,1,0,0,1, "R5 reti no defer on equal", 6'h3F, 6'b010110);
    cyc(0,0,0,0,0,1,1, "R3 cleared after reti",     6'h3F, 6'b000000);
    // Held low NMI must not retrigger
    cyc(1,1,0,0,0,1,1, "R2 EI",                     6'h00, 6'b000000);
    cyc(0,0,0,0,0,1,0, "R6 edge",                   6'h00, 6'b000000);
    cyc(1,0,0,0,0,1,0, "R8 nmi with iffs set",      6'h3F, 6'b101110);
    for (int i = 0; i < 5; i++)
      cyc(0,0,0,0,0,1,0, "R9 wait",                 6'h00, 6'b000000);
    cyc(0,0,0,0,0,1,0, "R9 window closed",          6'h3F, 6'b000010);
    cyc(1,0,0,0,0,0,0, "R6 R8 no retrigger no int", 6'h3F, 6'b000010);
    cyc(0,1,0,0,0,1,0, "R11 EI without boundary",   6'h00, 6'b000000);
    cyc(0,0,0,0,0,1,0, "R11 event ignored",         6'h3F, 6'b000010);
    #(CLK_PERIOD);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule